// File: doc/BRIEF.md
# CEA Progressive Video Timing Generator

This block produces the raster timing for a display output path. It counts pixels along a line and lines down a frame, and from those counts it derives horizontal and vertical sync, a data-enable flag that marks visible pixels, and a short preamble strobe that fires shortly before the visible part of every line. The downstream link encoder uses the strobe to place its video guard band. Five fixed progressive formats are held in a built-in table, and a 3-bit select input picks one of them.

The format is captured only while reset is held. After reset is released the generator free-runs for as long as the enable input is high. Dropping the enable freezes both counters and forces every timing output to its inactive level. The block also reports the total number of pixel clocks in one frame, so that other logic can compute the refresh rate from the pixel clock frequency.

Top module: `vtg_top`

## Requirements
- R1: `mode_sel` picks the format. Timing is listed as active / front porch / sync / back porch. Code 0: 640 / 16 / 96 / 48 horizontally and 480 / 10 / 2 / 33 vertically. Code 1: 720 / 16 / 62 / 60 and 480 / 9 / 6 / 30. Code 2: 720 / 12 / 64 / 68 and 576 / 5 / 5 / 39. Code 3: 1280 / 110 / 40 / 220 and 720 / 5 / 5 / 20. Code 4: 1920 / 88 / 44 / 148 and 1080 / 4 / 5 / 36. Codes 5 to 7 select the code 0 format.
- R2: Each line runs sync, back porch, active, front porch, starting at `h_cnt` = 0. `h_cnt` counts 0 to total-1 and then wraps. `v_cnt` advances in the same cycle as that wrap, and lines follow the same order vertically.
- R3: `hsync` is asserted for exactly the sync-width pixels at the start of each line. `vsync` is asserted for exactly the sync-width lines at the start of each frame. Codes 3 and 4 use active-high syncs; the other formats use active-low syncs.
- R4: `de` is high only when both `h_cnt` and `v_cnt` are inside their active regions.
- R5: `preamble` is high on every line for 8 pixels, starting at pixel (sync width + back porch - 10). It is active high.
- R6: `frame_pixels` equals (horizontal total) times (vertical total), where each total is active + front porch + sync + back porch.
- R7: The format is taken from `mode_sel` while `rst` is high. A change of `mode_sel` while the block is running has no effect.
- R8: While `en` is low, both counters hold their values and `hsync`, `vsync`, `de` and `preamble` sit at their inactive levels. When `en` returns high, counting resumes from the held position.
- R9: While `rst` is high, both counters read 0 and every timing output is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; format capture window |
| en | input | 1 | Run enable |
| mode_sel | input | 3 | Format code (see R1) |
| hsync | output | 1 | Horizontal sync, polarity per format |
| vsync | output | 1 | Vertical sync, polarity per format |
| de | output | 1 | Visible-pixel enable |
| preamble | output | 1 | Pre-active strobe, active high |
| h_cnt | output | 12 | Pixel position within the line |
| v_cnt | output | 12 | Line position within the frame |
| frame_pixels | output | 24 | Pixel clocks per frame |

## Verification
The end of a line and the step of the line counter happen in the same cycle. At the end of the last sync line, `vsync` must also release in that same cycle. Each format scan runs across the boundary after the final sync line and checks that `vsync` changes exactly at pixel 0 of the next line, never one pixel early or late. A second case freezes the enable while `hsync` is asserted mid-line. Here the counter hold and the forced inactive output levels coincide, and on resume the block must continue from the same pixel with `hsync` asserted again.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    parameter int unsigned AXIS_W  = 12;
    parameter int unsigned FRAME_W = 2 * AXIS_W;

    typedef logic [AXIS_W-1:0] axis_len_t;

    typedef enum logic [2:0] {
        MODE_VGA    = 3'd0,
        MODE_SD60   = 3'd1,
        MODE_SD50   = 3'd2,
        MODE_HD720  = 3'd3,
        MODE_HD1080 = 3'd4
    } vtg_mode_e;

    typedef struct packed {
        axis_len_t act;
        axis_len_t fp;
        axis_len_t sync;
        axis_len_t bp;
        logic      pol_hi;
    } axis_tim_t;

    typedef struct packed {
        axis_tim_t h;
        axis_tim_t v;
    } frame_tim_t;

    function automatic axis_tim_t mk_axis(input int unsigned a, input int unsigned f,
                                          input int unsigned s, input int unsigned b,
                                          input logic p);
        axis_tim_t t;
        t.act    = axis_len_t'(a);
        t.fp     = axis_len_t'(f);
        t.sync   = axis_len_t'(s);
        t.bp     = axis_len_t'(b);
        t.pol_hi = p;
        return t;
    endfunction

    function automatic axis_len_t axis_total(input axis_tim_t t);
        return t.act + t.fp + t.sync + t.bp;
    endfunction

    function automatic frame_tim_t vtg_lookup(input logic [2:0] code);
        frame_tim_t r;
        case (vtg_mode_e'(code))
            MODE_SD60: begin
                r.h = mk_axis(720, 16, 62, 60, 1'b0);
                r.v = mk_axis(480, 9, 6, 30, 1'b0);
            end
            MODE_SD50: begin
                r.h = mk_axis(720, 12, 64, 68, 1'b0);
                r.v = mk_axis(576, 5, 5, 39, 1'b0);
            end
            MODE_HD720: begin
                r.h = mk_axis(1280, 110, 40, 220, 1'b1);
                r.v = mk_axis(720, 5, 5, 20, 1'b1);
            end
            MODE_HD1080: begin
                r.h = mk_axis(1920, 88, 44, 148, 1'b1);
                r.v = mk_axis(1080, 4, 5, 36, 1'b1);
            end
            default: begin
                r.h = mk_axis(640, 16, 96, 48, 1'b0);
                r.v = mk_axis(480, 10, 2, 33, 1'b0);
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vtg_mode_reg.sv
module vtg_mode_reg
    import vtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    output frame_tim_t tim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tim <= vtg_lookup(mode_sel);
        end
    end

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(tim));

endmodule

// File: rtl/vtg_axis.sv
module vtg_axis
    import vtg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      inc,
    input  logic      gate,
    input  axis_tim_t tim,
    output axis_len_t cnt,
    output logic      last,
    output logic      act_on,
    output logic      sync_lvl
);

    axis_len_t total;
    axis_len_t act_lo;
    axis_len_t act_hi;
    logic      sync_on;

    always_comb begin
        total    = axis_total(tim);
        act_lo   = tim.sync + tim.bp;
        act_hi   = act_lo + tim.act;
        last     = (cnt == total - 1'b1);
        sync_on  = (cnt < tim.sync);
        act_on   = (cnt >= act_lo) && (cnt < act_hi);
        sync_lvl = tim.pol_hi ? (gate & sync_on) : ~(gate & sync_on);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        inc && last |=> cnt == '0);

    // R2
    step_chk: assert property (@(posedge clk) disable iff (rst)
        inc && !last |=> cnt == axis_len_t'($past(cnt) + 1'b1));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt));

endmodule

// File: rtl/vtg_preamble.sv
module vtg_preamble
    import vtg_pkg::*;
#(
    parameter int unsigned LEAD = 10,
    parameter int unsigned LEN  = 8
) (
    input  axis_len_t h_cnt,
    input  axis_len_t h_sync,
    input  axis_len_t h_bp,
    output logic      pulse
);

    axis_len_t start;

    always_comb begin
        start = h_sync + h_bp - axis_len_t'(LEAD);
        pulse = (h_cnt >= start) && (h_cnt < start + axis_len_t'(LEN));
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int unsigned PRE_LEAD = 10,
    parameter int unsigned PRE_LEN  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [2:0]         mode_sel,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic               preamble,
    output logic [AXIS_W-1:0]  h_cnt,
    output logic [AXIS_W-1:0]  v_cnt,
    output logic [FRAME_W-1:0] frame_pixels
);

    frame_tim_t tim;
    logic       gate;
    logic       h_last, v_last;
    logic       h_act, v_act;
    logic       pre_raw;

    assign gate = en & ~rst;

    vtg_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .tim      (tim)
    );

    vtg_axis u_h (
        .clk      (clk),
        .rst      (rst),
        .inc      (en),
        .gate     (gate),
        .tim      (tim.h),
        .cnt      (h_cnt),
        .last     (h_last),
        .act_on   (h_act),
        .sync_lvl (hsync)
    );

    vtg_axis u_v (
        .clk      (clk),
        .rst      (rst),
        .inc      (en & h_last),
        .gate     (gate),
        .tim      (tim.v),
        .cnt      (v_cnt),
        .last     (v_last),
        .act_on   (v_act),
        .sync_lvl (vsync)
    );

    vtg_preamble #(
        .LEAD (PRE_LEAD),
        .LEN  (PRE_LEN)
    ) u_pre (
        .h_cnt  (h_cnt),
        .h_sync (tim.h.sync),
        .h_bp   (tim.h.bp),
        .pulse  (pre_raw)
    );

    assign de           = gate & h_act & v_act;
    assign preamble     = gate & pre_raw;
    assign frame_pixels = FRAME_W'(axis_total(tim.h)) * FRAME_W'(axis_total(tim.v));

    // R4
    de_blank_chk: assert property (@(posedge clk) disable iff (rst)
        de |-> (hsync == ~tim.h.pol_hi) && (vsync == ~tim.v.pol_hi));

    // R5
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        preamble |-> !h_act);

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        en && h_last && v_last |=> (v_cnt == '0) && (h_cnt == '0));

    // R6
    frame_const_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(frame_pixels));

endmodule

// File: tb/test_vtg_top.sv
module test_vtg_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b1;
    logic [2:0]  mode_sel = 3'd0;
    logic        hsync, vsync, de, preamble;
    logic [11:0] h_cnt, v_cnt;
    logic [23:0] frame_pixels;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    vtg_top i_vtg_top (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .mode_sel     (mode_sel),
        .hsync        (hsync),
        .vsync        (vsync),
        .de           (de),
        .preamble     (preamble),
        .h_cnt        (h_cnt),
        .v_cnt        (v_cnt),
        .frame_pixels (frame_pixels)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] code);
        @(negedge clk);
        rst = 1'b1;
        en = 1'b1;
        mode_sel = code;
        repeat (3) @(negedge clk);
    endtask

    // Scans lines 0..nlines-1 of one format and compares every pixel.
    task automatic scan_mode(input logic [2:0] code, input string rq,
                             input int hact, input int hfp, input int hs, input int hbp,
                             input int vact, input int vfp, input int vs, input int vbp,
                             input bit pol, input int nlines, input bit swap);
        int htot = hact + hfp + hs + hbp;
        int vtot = vact + vfp + vs + vbp;
        int e_cnt = 0, e_hs = 0, e_vs = 0, e_de = 0, e_pre = 0;
        int a_cnt = 0, x_cnt = 0;
        int pre_lo = hs + hbp - 10;
        do_reset(code);
        rst = 1'b0;
        #1;
        for (int ln = 0; ln < nlines; ln++) begin
            for (int px = 0; px < htot; px++) begin
                bit hs_on, vs_on, de_exp, pre_exp;
                if (!(ln == 0 && px == 0)) @(negedge clk);
                if (swap && ln == 0 && px == 20) mode_sel = 3'd4;
                hs_on   = px < hs;
                vs_on   = ln < vs;
                de_exp  = (px >= hs + hbp) && (px < hs + hbp + hact) &&
                          (ln >= vs + vbp) && (ln < vs + vbp + vact);
                pre_exp = (px >= pre_lo) && (px < pre_lo + 8);
                if (int'(h_cnt) != px || int'(v_cnt) != ln) begin
                    if (e_cnt == 0) begin a_cnt = int'(h_cnt); x_cnt = px; end
                    e_cnt++;
                end
                if (hsync != (pol ? hs_on : !hs_on)) e_hs++;
                if (vsync != (pol ? vs_on : !vs_on)) e_vs++;
                if (de != de_exp) e_de++;
                if (preamble != pre_exp) e_pre++;
            end
        end
        // R2 counter sequence including the line wrap
        chk(e_cnt == 0, "R2", "pixel/line counter sequence, first h_cnt", a_cnt, x_cnt);
        // R3 sync widths and polarity, vsync edge at line boundary
        chk(e_hs == 0, "R3", "hsync mismatching pixels", e_hs, 0);
        chk(e_vs == 0, "R3", "vsync mismatching pixels", e_vs, 0);
        // R4 active region
        chk(e_de == 0, "R4", "de mismatching pixels", e_de, 0);
        // R5 preamble placement
        chk(e_pre == 0, "R5", "preamble mismatching pixels", e_pre, 0);
        // R6 frame size, R1 table content
        chk(int'(frame_pixels) == htot * vtot, rq, "frame_pixels", int'(frame_pixels), htot * vtot);
    endtask

    task automatic test_reset_state();
        do_reset(3'd3);
        // R9 reset values, HD format: inactive syncs are low
        chk(h_cnt == 0 && v_cnt == 0, "R9", "counters in reset", int'(h_cnt), 0);
        chk(hsync == 1'b0 && vsync == 1'b0, "R9", "HD syncs in reset", int'(hsync), 0);
        chk(de == 1'b0 && preamble == 1'b0, "R9", "de/preamble in reset", int'(de), 0);
        do_reset(3'd0);
        // R9 SD format: inactive syncs are high
        chk(hsync == 1'b1 && vsync == 1'b1, "R9", "SD syncs in reset", int'(hsync), 1);
    endtask

    task automatic test_enable_hold();
        do_reset(3'd0);
        rst = 1'b0;
        #1;
        repeat (50) @(negedge clk);
        chk(h_cnt == 50 && hsync == 1'b0, "R8", "position before hold", int'(h_cnt), 50);
        en = 1'b0;
        #1;
        chk(hsync == 1'b1 && vsync == 1'b1, "R8", "syncs inactive while disabled", int'(hsync), 1);
        repeat (20) @(negedge clk);
        chk(h_cnt == 50 && v_cnt == 0, "R8", "h_cnt held while disabled", int'(h_cnt), 50);
        chk(de == 1'b0 && preamble == 1'b0, "R8", "de/preamble while disabled", int'(de), 0);
        en = 1'b1;
        #1;
        chk(h_cnt == 50 && hsync == 1'b0, "R8", "resume position and hsync", int'(h_cnt), 50);
        @(negedge clk);
        chk(h_cnt == 51, "R8", "counting resumes", int'(h_cnt), 51);
    endtask

    initial begin
        test_reset_state();
        scan_mode(3'd0, "R1", 640, 16, 96, 48, 480, 10, 2, 33, 1'b0, 36, 1'b0);
        scan_mode(3'd1, "R1", 720, 16, 62, 60, 480, 9, 6, 30, 1'b0, 37, 1'b0);
        scan_mode(3'd2, "R6", 720, 12, 64, 68, 576, 5, 5, 39, 1'b0, 6, 1'b0);
        scan_mode(3'd3, "R6", 1280, 110, 40, 220, 720, 5, 5, 20, 1'b1, 6, 1'b0);
        scan_mode(3'd4, "R6", 1920, 88, 44, 148, 1080, 4, 5, 36, 1'b1, 6, 1'b0);
        // R1 unused code falls back to the code 0 format
        scan_mode(3'd5, "R1", 640, 16, 96, 48, 480, 10, 2, 33, 1'b0, 3, 1'b0);
        // R7 select change while running is ignored
        scan_mode(3'd0, "R7", 640, 16, 96, 48, 480, 10, 2, 33, 1'b0, 3, 1'b1);
        test_enable_hold();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule